// File: doc/BRIEF.md
# Write-Through Line Flush and Purge Walker

This block runs a flush or purge command through a write-through level-one data cache whose lines are smaller than those of the cache below it. The command names one lower-level line. The block therefore visits every level-one block that the lower-level line covers. It visits them in ascending order, one block per clock cycle.

At each block the walker first looks for a miss that is still outstanding for that block. It does this by comparing the block number against a snapshot of the miss-status registers. If one of them matches, the operation is handed to that register, which records the pending command type and stops taking further coalesced requests. The tag array is then left alone for that block. If nothing matches, the walker probes the tag array. A hit is invalidated without any data writeback, because the cache never holds dirty data. When the invalidated line had been filled by a prefetch, a useless-prefetch event is raised for that prefetch source.

When the cache is configured for writeback, a flush has nothing to do. It completes one cycle after it is accepted. A purge is always walked.

Top module: `fpw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, probe_valid, inval_valid, mark_valid, useless_swpf and useless_hwpf are all low.
- R2: A walked command covers L2_BYTES/L1_BYTES consecutive level-one blocks. It starts at the command address aligned down to L2_BYTES, and the block number is the address shifted right by log2(L1_BYTES). One block is visited per cycle in ascending order, starting the cycle after acceptance.
- R3: When a valid MSHR entry holds the visited block number, mark_valid is high with mark_sel selecting that entry. In the same cycle mark_purge equals the command type (1 = purge, 0 = flush), and neither probe_valid nor inval_valid is asserted.
- R4: When several valid entries match, only the lowest-indexed one is selected, and mark_sel has exactly one bit set.
- R5: An entry whose valid bit is low never matches, even when its block number is equal.
- R6: When no entry matches, probe_valid is high with probe_blk equal to the visited block. If probe_hit is high in that cycle, inval_valid is high with inval_blk equal to the same block. If probe_hit is low, no invalidate is issued.
- R7: On an invalidate, probe_src = 1 (software prefetch fill) pulses useless_swpf, and probe_src = 2 (hardware prefetch fill) pulses useless_hwpf. Values 0 and 3 pulse neither.
- R8: A purge is always walked. A flush is walked only while cfg_write_through is 1. With cfg_write_through at 0, a flush causes no probe and no mark, and it pulses done in the cycle after acceptance.
- R9: busy is high for exactly the walk cycles. done is a single-cycle pulse in the cycle after the last visited block, and busy is low while done is high.
- R10: cmd_valid is ignored while busy is high. The walk in progress keeps its address and type, and no further walk follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; taken when busy is low |
| cmd_purge | input | 1 | 1 = purge, 0 = flush |
| cmd_addr | input | ADDR_W | Physical byte address inside the target lower-level line |
| cfg_write_through | input | 1 | 1 = cache runs write-through, so flushes are walked |
| mshr_valid | input | NUM_MSHR | Valid bit of each miss-status register |
| mshr_blocks | input | NUM_MSHR*BLK_W | Block number of each register, entry 0 in the low bits |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| probe_valid | output | 1 | Tag-array lookup request this cycle |
| probe_blk | output | BLK_W | Block number being looked up |
| probe_hit | input | 1 | Same-cycle lookup result: line present |
| probe_src | input | 2 | Fill source of the probed line: 0 demand, 1 software prefetch, 2 hardware prefetch |
| inval_valid | output | 1 | Invalidate the probed line (state invalid, tag all ones) |
| inval_blk | output | BLK_W | Block number to invalidate |
| mark_valid | output | 1 | Defer the operation onto one MSHR entry |
| mark_sel | output | NUM_MSHR | One-hot entry select for the mark |
| mark_purge | output | 1 | Pending operation type written into the entry |
| useless_swpf | output | 1 | Invalidated line came from a software prefetch |
| useless_hwpf | output | 1 | Invalidated line came from a hardware prefetch |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-byte level-one lines, 64-byte lower-level lines and four MSHR entries. That gives a four-step walk with a two-bit step field, so every step of a walk can be matched, hit or missed on its own. Four entries are enough to place two valid matches on one block to test the lowest-index rule. An equal but invalid entry can sit beside them, and different steps can end up deferred versus invalidated within a single walk. Unaligned command addresses and a second command offered mid-walk exercise the alignment and ignore rules.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
   typedef enum logic {
      FPW_OP_FLUSH = 1'b0,
      FPW_OP_PURGE = 1'b1
   } fpw_op_e;

   typedef enum logic [1:0] {
      FPW_SRC_DEMAND = 2'd0,
      FPW_SRC_SWPF   = 2'd1,
      FPW_SRC_HWPF   = 2'd2,
      FPW_SRC_RSVD   = 2'd3
   } fpw_src_e;
endpackage

// File: rtl/fpw_mshr_match.sv
module fpw_mshr_match #(
   parameter int NUM_MSHR = 4,
   parameter int BLK_W    = 28
) (
   input  logic [BLK_W-1:0]          blk,
   input  logic [NUM_MSHR-1:0]       ent_valid,
   input  logic [NUM_MSHR*BLK_W-1:0] ent_blocks,
   output logic                      any_hit,
   output logic [NUM_MSHR-1:0]       first_sel
);
   logic [NUM_MSHR-1:0] eq;
   logic [NUM_MSHR:0]   seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM_MSHR; i++) begin : g_ent
      assign eq[i]        = ent_valid[i] && (ent_blocks[i*BLK_W +: BLK_W] == blk);
      assign first_sel[i] = eq[i] && !seen[i];
      assign seen[i+1]    = seen[i] || eq[i];
   end

   assign any_hit = seen[NUM_MSHR];
endmodule

// File: rtl/fpw_step_ctrl.sv
module fpw_step_ctrl #(
   parameter int STEP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              walk,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              done
);
   localparam logic [STEP_W-1:0] LAST_STEP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (step == LAST_STEP) begin
               busy <= 1'b0;
               done <= 1'b1;
               step <= '0;
            end else begin
               step <= step + 1'b1;
            end
         end else if (accept) begin
            if (walk) begin
               busy <= 1'b1;
               step <= '0;
            end else begin
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fpw_walker.sv
module fpw_walker #(
   parameter int ADDR_W   = 32,
   parameter int L1_BYTES = 16,
   parameter int L2_BYTES = 64,
   parameter int NUM_MSHR = 4,
   localparam int L1_SHIFT = $clog2(L1_BYTES),
   localparam int L2_SHIFT = $clog2(L2_BYTES),
   localparam int STEP_W   = L2_SHIFT - L1_SHIFT,
   localparam int BLK_W    = ADDR_W - L1_SHIFT,
   localparam int GRP_W    = ADDR_W - L2_SHIFT
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_valid,
   input  logic                      cmd_purge,
   input  logic [ADDR_W-1:0]         cmd_addr,
   input  logic                      cfg_write_through,
   input  logic [NUM_MSHR-1:0]       mshr_valid,
   input  logic [NUM_MSHR*BLK_W-1:0] mshr_blocks,
   output logic                      busy,
   output logic                      done,
   output logic                      probe_valid,
   output logic [BLK_W-1:0]          probe_blk,
   input  logic                      probe_hit,
   input  logic [1:0]                probe_src,
   output logic                      inval_valid,
   output logic [BLK_W-1:0]          inval_blk,
   output logic                      mark_valid,
   output logic [NUM_MSHR-1:0]       mark_sel,
   output logic                      mark_purge,
   output logic                      useless_swpf,
   output logic                      useless_hwpf
);
   import fpw_pkg::*;

   if (L1_BYTES != (1 << L1_SHIFT) || L2_BYTES != (1 << L2_SHIFT)) begin : g_bad_pow2
      $error("fpw_walker: line sizes must be powers of two");
   end
   if (L2_BYTES <= L1_BYTES) begin : g_bad_ratio
      $error("fpw_walker: lower-level line must be larger than level-one line");
   end
   if (NUM_MSHR < 1 || L2_SHIFT >= ADDR_W) begin : g_bad_size
      $error("fpw_walker: bad MSHR count or address width");
   end

   logic              accept;
   logic              walk_needed;
   logic [STEP_W-1:0] step;
   logic [GRP_W-1:0]  grp_q;
   fpw_op_e           op_q;
   logic [BLK_W-1:0]  step_blk;
   logic              defer_hit;
   logic [NUM_MSHR-1:0] defer_sel;
   fpw_src_e          src;

   assign accept      = cmd_valid && !busy;
   assign walk_needed = cmd_purge || cfg_write_through;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= '0;
         op_q  <= FPW_OP_FLUSH;
      end else if (accept) begin
         grp_q <= cmd_addr[ADDR_W-1:L2_SHIFT];
         op_q  <= cmd_purge ? FPW_OP_PURGE : FPW_OP_FLUSH;
      end
   end

   fpw_step_ctrl #(.STEP_W(STEP_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .walk   (walk_needed),
      .busy   (busy),
      .step   (step),
      .done   (done)
   );

   assign step_blk = {grp_q, step};

   fpw_mshr_match #(.NUM_MSHR(NUM_MSHR), .BLK_W(BLK_W)) u_match (
      .blk        (step_blk),
      .ent_valid  (mshr_valid),
      .ent_blocks (mshr_blocks),
      .any_hit    (defer_hit),
      .first_sel  (defer_sel)
   );

   assign src          = fpw_src_e'(probe_src);
   assign mark_valid   = busy && defer_hit;
   assign mark_sel     = busy ? defer_sel : '0;
   assign mark_purge   = (op_q == FPW_OP_PURGE);
   assign probe_valid  = busy && !defer_hit;
   assign probe_blk    = step_blk;
   assign inval_valid  = probe_valid && probe_hit;
   assign inval_blk    = step_blk;
   assign useless_swpf = inval_valid && (src == FPW_SRC_SWPF);
   assign useless_hwpf = inval_valid && (src == FPW_SRC_HWPF);

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (probe_valid ^ mark_valid));                              // R3
   AST_NO_INVAL_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      mark_valid |-> !inval_valid && !useless_swpf && !useless_hwpf);    // R3
   AST_MARK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      mark_valid |-> $countones(mark_sel) == 1);                         // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !probe_valid && !mark_valid && !inval_valid);            // R8
   AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> step_blk == $past(step_blk) + 1'b1);       // R2
   AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> step == '0);                                       // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R9
   AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(mark_purge));                      // R10
endmodule

// File: tb/fpw_walker_tb.sv
module fpw_walker_tb_top;
   localparam int AW  = 32;
   localparam int NM  = 4;
   localparam int BW  = 28;
   localparam int NST = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_purge = 1'b0, cfg_wt = 1'b1;
   logic [AW-1:0] cmd_addr = '0;
   logic [NM-1:0] mv = '0;
   logic [BW-1:0] mb [NM];
   logic [NM*BW-1:0] mshr_blocks;
   logic busy, done, probe_valid, probe_hit, inval_valid, mark_valid, mark_purge;
   logic useless_swpf, useless_hwpf;
   logic [1:0] probe_src;
   logic [BW-1:0] probe_blk, inval_blk;
   logic [NM-1:0] mark_sel;
   logic [NST-1:0] hit_mask = '0;
   logic [1:0] src_t [NST];

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign mshr_blocks = {mb[3], mb[2], mb[1], mb[0]};
   assign probe_hit   = hit_mask[probe_blk[1:0]];
   assign probe_src   = src_t[probe_blk[1:0]];

   fpw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_purge(cmd_purge),
      .cmd_addr(cmd_addr), .cfg_write_through(cfg_wt), .mshr_valid(mv),
      .mshr_blocks(mshr_blocks), .busy(busy), .done(done),
      .probe_valid(probe_valid), .probe_blk(probe_blk), .probe_hit(probe_hit),
      .probe_src(probe_src), .inval_valid(inval_valid), .inval_blk(inval_blk),
      .mark_valid(mark_valid), .mark_sel(mark_sel), .mark_purge(mark_purge),
      .useless_swpf(useless_swpf), .useless_hwpf(useless_hwpf)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_env();
      mv = '0; hit_mask = '0;
      for (int i = 0; i < NM; i++) mb[i] = '0;
      for (int i = 0; i < NST; i++) src_t[i] = 2'd0;
   endtask

   // Walks one command and checks every step against a model of R2-R10.
   task automatic do_walk(input bit purge, input logic [AW-1:0] addr, input bit inject);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_purge = purge; cmd_addr = addr;
      for (int k = 0; k < NST; k++) begin
         logic [BW-1:0] blk;
         int m;
         @(negedge clk);
         if (k == 0) cmd_valid = 1'b0;
         blk = {addr[AW-1:6], 2'(k)};
         m = -1;
         for (int i = 0; i < NM; i++)
            if (m < 0 && mv[i] && mb[i] == blk) m = i;
         chk(busy == 1'b1, "R9 busy during walk", busy, 1);
         chk(done == 1'b0, "R9 no done mid-walk", done, 0);
         if (m >= 0) begin
            chk(mark_valid == 1'b1, "R3 mark on match", mark_valid, 1);
            chk(mark_sel == NM'(1 << m), "R4 lowest index select", mark_sel, 1 << m);
            chk(mark_purge == purge, "R3 mark type (R10 kept)", mark_purge, purge);
            chk(probe_valid == 1'b0 && inval_valid == 1'b0, "R3 no probe on match",
                {probe_valid, inval_valid}, 0);
         end else begin
            chk(mark_valid == 1'b0, "R5 no mark without valid match", mark_valid, 0);
            chk(probe_valid == 1'b1, "R6 probe issued", probe_valid, 1);
            chk(probe_blk == blk, "R2 probe block order/alignment", probe_blk, blk);
            chk(inval_valid == hit_mask[k], "R6 invalidate on hit", inval_valid, hit_mask[k]);
            if (hit_mask[k])
               chk(inval_blk == blk, "R6 invalidate block", inval_blk, blk);
            chk(useless_swpf == (hit_mask[k] && src_t[k] == 2'd1), "R7 sw prefetch event",
                useless_swpf, hit_mask[k] && src_t[k] == 2'd1);
            chk(useless_hwpf == (hit_mask[k] && src_t[k] == 2'd2), "R7 hw prefetch event",
                useless_hwpf, hit_mask[k] && src_t[k] == 2'd2);
         end
         if (inject && k == 1) begin
            cmd_valid = 1'b1; cmd_purge = ~purge; cmd_addr = addr ^ 32'h0000_1000;
         end
         if (inject && k == 2) cmd_valid = 1'b0;
      end
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R9 done after last step", {done, busy}, 2'b10);
      chk(probe_valid == 1'b0 && mark_valid == 1'b0, "R9 quiet at done",
          {probe_valid, mark_valid}, 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R10 R9 single pulse, no extra walk",
          {done, busy}, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !probe_valid && !inval_valid && !mark_valid &&
          !useless_swpf && !useless_hwpf, "R1 reset state",
          {busy, done, probe_valid, inval_valid, mark_valid}, 0);
   endtask

   task automatic t_purge_hits();
      clear_env();
      hit_mask = 4'b1111;
      src_t[0] = 2'd0; src_t[1] = 2'd1; src_t[2] = 2'd2; src_t[3] = 2'd3;
      do_walk(1'b1, 32'h1234_5678, 1'b0);   // unaligned address, R2 R7
   endtask

   task automatic t_purge_misses();
      clear_env();
      hit_mask = 4'b0101;
      src_t[0] = 2'd1; src_t[1] = 2'd2;
      do_walk(1'b1, 32'h0000_00C0, 1'b0);   // R6 misses leave no invalidate
   endtask

   task automatic t_flush_mshr();
      logic [BW-1:0] base;
      clear_env();
      cfg_wt = 1'b1;
      base = {26'h2AB_CDE, 2'b00};
      hit_mask = 4'b1111;
      mv = 4'b1110;
      mb[0] = base + 1;                     // invalid entry, R5
      mb[1] = base + 2;                     // R3
      mb[2] = base + 3;                     // R4 duplicate with entry 3
      mb[3] = base + 3;
      do_walk(1'b0, {base, 4'h9}, 1'b0);
   endtask

   task automatic t_wb_flush();
      clear_env();
      hit_mask = 4'b1111;
      cfg_wt = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_purge = 1'b0; cmd_addr = 32'h0000_4000;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b0 && done == 1'b1, "R8 writeback flush completes at once",
          {busy, done}, 2'b01);
      chk(probe_valid == 1'b0 && mark_valid == 1'b0 && inval_valid == 1'b0,
          "R8 writeback flush touches nothing", {probe_valid, mark_valid, inval_valid}, 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8 R9 done is a pulse", {done, busy}, 0);
      do_walk(1'b1, 32'h0000_4010, 1'b0);   // R8 purge still walked
      cfg_wt = 1'b1;
   endtask

   task automatic t_busy_ignore();
      clear_env();
      hit_mask = 4'b0010;
      mb[0] = {26'h000_0033, 2'b11};
      mv = 4'b0001;
      do_walk(1'b1, 32'h0000_0CC4, 1'b1);   // R10
   endtask

   initial begin
      clear_env();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_purge_hits();
      t_purge_misses();
      t_flush_mshr();
      t_wb_flush();
      t_busy_ignore();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule